// File: doc/BRIEF.md
# Store Buffer with Youngest-Match Load Forwarding

This block sits between a core's store port and its data cache. A store is taken into a small in-order queue in the cycle it is offered. It does not wait for any coherence reply from another cache. The oldest queued store is shown on a drain port toward the cache. It leaves the queue, and its data is written to the cache, only in the cycle in which the cache grants ownership of its line.

Loads are looked up in the queue in the same cycle as the cache. When one or more queued stores match the load address, the youngest of them supplies the load data. Otherwise the data read from the cache passes through unchanged.

A write-barrier pulse stops later stores from entering until every store queued before the barrier has drained. During that time the store port holds the core with a ready/valid handshake, and it does the same while the queue is full.

Top module: `store_fwd_buffer`

## Requirements
- R1: After reset the queue is empty: `st_ready` is 1, `dr_valid` is 0 and `ld_hit` is 0.
- R2: A store offered with `st_valid` high while `st_ready` is high is taken at that clock edge whether or not `dr_grant` is asserted. From the next cycle it appears on the drain port if it is the oldest entry.
- R3: While `ld_valid` is high and a queued store has address `ld_addr`, `ld_hit` is 1 and `ld_rdata` carries the queued data in the same cycle.
- R4: When no queued store matches, `ld_hit` is 0 and `ld_rdata` equals `ld_cache_data`.
- R5: When several queued stores match the load address, `ld_rdata` returns the data of the most recently accepted one.
- R6: The oldest entry stays on `dr_addr`/`dr_data` with `dr_valid` high until a cycle with `dr_grant` high, and it is removed at that edge.
- R7: Entries drain strictly in the order in which they were accepted.
- R8: With 4 entries queued, `st_ready` is 0 and an offered store is held. It is accepted once an entry has drained.
- R9: A `wbar` pulse drives `st_ready` low from the next cycle. `st_ready` stays low until the cycle after the queue becomes empty. A store accepted in the same cycle as `wbar` counts as earlier than the barrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request valid |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_ready | output | 1 | Store can be accepted this cycle |
| wbar | input | 1 | Write-barrier pulse |
| ld_valid | input | 1 | Load lookup valid |
| ld_addr | input | AW | Load address |
| ld_cache_data | input | DW | Data read from the cache for this load |
| ld_hit | output | 1 | Load matched a queued store |
| ld_rdata | output | DW | Load result: forwarded or cache data |
| dr_valid | output | 1 | Oldest entry present on drain port |
| dr_addr | output | AW | Address of oldest entry |
| dr_data | output | DW | Data of oldest entry |
| dr_grant | input | 1 | Ownership granted; oldest entry is written to cache and popped |

## Verification
The assertions assume that `dr_grant` is meaningful only while `dr_valid` is high, and that the core keeps a held store stable while `st_ready` is low. They do not depend on `wbar` being a single-cycle pulse, but the reopening time in R9 counts from the last cycle of `wbar`. The stimulus raises `dr_grant` only for one cycle while an entry is showing. It keeps `st_valid` and the store fields constant until acceptance. It pulses `wbar` for exactly one cycle, sometimes together with a store to exercise the same-cycle ordering.

// File: rtl/sb_pkg.sv
// Package: shared types for the store buffer.
// Assumes nothing beyond the enum width being 1 bit.
package sb_pkg;
    typedef enum logic {
        BAR_OPEN = 1'b0,   // stores flow normally
        BAR_HOLD = 1'b1    // barrier waiting for the queue to empty
    } bar_state_t;
endpackage

// File: rtl/sb_queue.sv
// In-order circular store queue. Pushes at the tail, pops at the head.
// Presents its contents in age order (index 0 = oldest) for forwarding.
// Assumes DEPTH is a power of two and push is never asserted when full.
module sb_queue #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [AW-1:0]             push_addr,
    input  logic [DW-1:0]             push_data,
    input  logic                      pop,
    output logic [CW-1:0]             occ,
    output logic [DEPTH-1:0]          ord_valid,
    output logic [DEPTH-1:0][AW-1:0]  ord_addr,
    output logic [DEPTH-1:0][DW-1:0]  ord_data
);
    logic [DEPTH-1:0][AW-1:0] addr_mem;
    logic [DEPTH-1:0][DW-1:0] data_mem;
    logic [PW-1:0]            head;
    logic [PW-1:0]            tail;

    // Pointer and occupancy update; pop only when something is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
            occ  <= '0;
        end else begin
            if (push) tail <= tail + PW'(1);
            if (pop)  head <= head + PW'(1);
            if (push && !pop)      occ <= occ + CW'(1);
            else if (pop && !push) occ <= occ - CW'(1);
        end
    end

    // Entry storage write at the tail slot.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_mem[tail] <= push_addr;
            data_mem[tail] <= push_data;
        end
    end

    // Age-ordered view: slot head+i holds the i-th oldest entry.
    for (genvar i = 0; i < DEPTH; i++) begin : g_age
        logic [PW-1:0] slot;
        assign slot         = head + PW'(i);
        assign ord_valid[i] = (CW'(i) < occ);
        assign ord_addr[i]  = addr_mem[slot];
        assign ord_data[i]  = data_mem[slot];
    end
endmodule

// File: rtl/sb_match.sv
// Load forwarding search. Scans entries oldest to youngest so the
// youngest matching entry wins; falls back to the cache data on a miss.
// Assumes age order on the inputs (index 0 = oldest).
module sb_match #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic                      ld_valid,
    input  logic [AW-1:0]             ld_addr,
    input  logic [DW-1:0]             ld_cache_data,
    input  logic [DEPTH-1:0]          ord_valid,
    input  logic [DEPTH-1:0][AW-1:0]  ord_addr,
    input  logic [DEPTH-1:0][DW-1:0]  ord_data,
    output logic                      hit,
    output logic [DW-1:0]             rdata
);
    logic [DEPTH-1:0] match;

    // Per-entry address compare.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = ld_valid && ord_valid[i] && (ord_addr[i] == ld_addr);
    end

    // Priority select: later (younger) matches override earlier ones.
    always_comb begin
        hit   = 1'b0;
        rdata = ld_cache_data;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                hit   = 1'b1;
                rdata = ord_data[i];
            end
        end
    end
endmodule

// File: rtl/sb_barrier.sv
// Write-barrier tracker. Enters HOLD on a barrier pulse and returns to
// OPEN once the queue has been observed empty while holding.
// Assumes occ reflects the queue occupancy at the start of the cycle.
module sb_barrier #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wbar,
    input  logic [CW-1:0] occ,
    output logic          hold
);
    import sb_pkg::*;
    bar_state_t state;

    // Barrier state transition.
    always_ff @(posedge clk) begin
        if (!rst_n)                            state <= BAR_OPEN;
        else if (wbar)                         state <= BAR_HOLD;
        else if (state == BAR_HOLD && occ == '0) state <= BAR_OPEN;
    end

    assign hold = (state == BAR_HOLD);
endmodule

// File: rtl/store_fwd_buffer.sv
// Store buffer top: accepts stores without waiting on coherence,
// drains them in order on ownership grant, forwards to loads, and
// honours a write barrier. Assumes dr_grant is only acted on with dr_valid.
module store_fwd_buffer #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    output logic          st_ready,
    input  logic          wbar,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_cache_data,
    output logic          ld_hit,
    output logic [DW-1:0] ld_rdata,
    output logic          dr_valid,
    output logic [AW-1:0] dr_addr,
    output logic [DW-1:0] dr_data,
    input  logic          dr_grant
);
    logic [CW-1:0]             occ;
    logic [DEPTH-1:0]          ord_valid;
    logic [DEPTH-1:0][AW-1:0]  ord_addr;
    logic [DEPTH-1:0][DW-1:0]  ord_data;
    logic                      hold;
    logic                      push;
    logic                      pop;

    // Handshake and drain control.
    assign st_ready = (occ != CW'(DEPTH)) && !hold;
    assign push     = st_valid && st_ready;
    assign dr_valid = ord_valid[0];
    assign dr_addr  = ord_addr[0];
    assign dr_data  = ord_data[0];
    assign pop      = dr_valid && dr_grant;

    sb_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (st_addr),
        .push_data (st_data),
        .pop       (pop),
        .occ       (occ),
        .ord_valid (ord_valid),
        .ord_addr  (ord_addr),
        .ord_data  (ord_data)
    );

    sb_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
        .ld_valid      (ld_valid),
        .ld_addr       (ld_addr),
        .ld_cache_data (ld_cache_data),
        .ord_valid     (ord_valid),
        .ord_addr      (ord_addr),
        .ord_data      (ord_data),
        .hit           (ld_hit),
        .rdata         (ld_rdata)
    );

    sb_barrier #(.CW(CW)) u_bar (
        .clk   (clk),
        .rst_n (rst_n),
        .wbar  (wbar),
        .occ   (occ),
        .hold  (hold)
    );
endmodule

// File: rtl/sb_checker.sv
// Checker for store_fwd_buffer; observes ports and the occupancy count.
// Assumes the bound instance uses the same DEPTH as the top.
module sb_checker #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          st_ready,
    input logic          wbar,
    input logic          ld_hit,
    input logic [DW-1:0] ld_rdata,
    input logic [DW-1:0] ld_cache_data,
    input logic          dr_valid,
    input logic [AW-1:0] dr_addr,
    input logic [DW-1:0] dr_data,
    input logic          dr_grant,
    input logic [CW-1:0] occ
);
    a_r1_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> (!dr_valid && !ld_hit));

    a_r2_accept_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && !(dr_valid && dr_grant)) |=> (occ == $past(occ) + CW'(1)));

    a_r4_miss_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_hit |-> (ld_rdata == ld_cache_data));

    a_r6_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_valid && !dr_grant) |=> (dr_valid && $stable(dr_addr) && $stable(dr_data)));

    a_r8_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CW'(DEPTH)) |-> !st_ready);

    a_r9_barrier_closes: assert property (@(posedge clk) disable iff (!rst_n)
        wbar |=> !st_ready);
endmodule

bind store_fwd_buffer sb_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .st_valid      (st_valid),
    .st_ready      (st_ready),
    .wbar          (wbar),
    .ld_hit        (ld_hit),
    .ld_rdata      (ld_rdata),
    .ld_cache_data (ld_cache_data),
    .dr_valid      (dr_valid),
    .dr_addr       (dr_addr),
    .dr_data       (dr_data),
    .dr_grant      (dr_grant),
    .occ           (occ)
);

// File: tb/sim_store_fwd_buffer.sv
// Directed bench for store_fwd_buffer: one task per scenario.
module sim_store_fwd_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          st_ready;
    logic          wbar = 1'b0;
    logic          ld_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_cache_data = '0;
    logic          ld_hit;
    logic [DW-1:0] ld_rdata;
    logic          dr_valid;
    logic [AW-1:0] dr_addr;
    logic [DW-1:0] dr_data;
    logic          dr_grant = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    store_fwd_buffer #(.DEPTH(4), .AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_ready(st_ready), .wbar(wbar),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_cache_data(ld_cache_data),
        .ld_hit(ld_hit), .ld_rdata(ld_rdata), .dr_valid(dr_valid),
        .dr_addr(dr_addr), .dr_data(dr_data), .dr_grant(dr_grant)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Offer a store and wait until it is accepted.
    task automatic push_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        st_valid = 1'b1; st_addr = a; st_data = d;
        while (!st_ready) tick();
        tick();
        st_valid = 1'b0;
    endtask

    // Grant the head entry for one cycle, checking the expected head first.
    task automatic drain_one(input string req, input logic [AW-1:0] ea, input logic [DW-1:0] ed);
        chk(req, "dr_valid", 64'(dr_valid), 64'd1);
        chk(req, "dr_addr", 64'(dr_addr), 64'(ea));
        chk(req, "dr_data", 64'(dr_data), 64'(ed));
        dr_grant = 1'b1;
        tick();
        dr_grant = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "st_ready", 64'(st_ready), 64'd1);
        chk("R1", "dr_valid", 64'(dr_valid), 64'd0);
        ld_valid = 1'b1; ld_addr = 16'h0000; ld_cache_data = 32'h5555;
        #1;
        chk("R1", "ld_hit", 64'(ld_hit), 64'd0);
        ld_valid = 1'b0;
    endtask

    task automatic t_forward();
        push_store(16'h0010, 32'hA0);
        chk("R2", "dr_valid after accept", 64'(dr_valid), 64'd1);
        chk("R2", "dr_addr after accept", 64'(dr_addr), 64'h10);
        push_store(16'h0020, 32'hB0);
        push_store(16'h0030, 32'hC0);
        ld_valid = 1'b1; ld_addr = 16'h0020; ld_cache_data = 32'hDEAD;
        #1;
        chk("R3", "ld_hit", 64'(ld_hit), 64'd1);
        chk("R3", "ld_rdata", 64'(ld_rdata), 64'hB0);
        ld_addr = 16'h0099;
        #1;
        chk("R4", "ld_hit miss", 64'(ld_hit), 64'd0);
        chk("R4", "ld_rdata miss", 64'(ld_rdata), 64'hDEAD);
        ld_valid = 1'b0;
        tick(); tick();
        chk("R6", "head held without grant", 64'(dr_addr), 64'h10);
        drain_one("R7", 16'h0010, 32'hA0);
        drain_one("R7", 16'h0020, 32'hB0);
        drain_one("R7", 16'h0030, 32'hC0);
        chk("R6", "empty after drains", 64'(dr_valid), 64'd0);
    endtask

    task automatic t_youngest();
        push_store(16'h0040, 32'h1);
        push_store(16'h0050, 32'h7);
        push_store(16'h0040, 32'h2);
        ld_valid = 1'b1; ld_addr = 16'h0040; ld_cache_data = 32'hFFFF;
        #1;
        chk("R5", "youngest data", 64'(ld_rdata), 64'h2);
        ld_valid = 1'b0;
        drain_one("R7", 16'h0040, 32'h1);
        drain_one("R7", 16'h0050, 32'h7);
        drain_one("R7", 16'h0040, 32'h2);
    endtask

    task automatic t_full();
        for (int i = 0; i < 4; i++) push_store(16'(16'h0100 + i), 32'(32'h100 + i));
        chk("R8", "st_ready when full", 64'(st_ready), 64'd0);
        st_valid = 1'b1; st_addr = 16'h0200; st_data = 32'h200;
        tick(); tick();
        chk("R8", "held store not taken", 64'(st_ready), 64'd0);
        chk("R8", "head unchanged", 64'(dr_addr), 64'h100);
        drain_one("R8", 16'h0100, 32'h100);
        chk("R8", "ready after drain", 64'(st_ready), 64'd1);
        tick();
        st_valid = 1'b0;
        for (int i = 1; i < 4; i++) drain_one("R7", 16'(16'h0100 + i), 32'(32'h100 + i));
        drain_one("R8", 16'h0200, 32'h200);
    endtask

    task automatic t_barrier();
        push_store(16'h0300, 32'h30);
        st_valid = 1'b1; st_addr = 16'h0310; st_data = 32'h31; wbar = 1'b1;
        tick();
        wbar = 1'b0;
        st_addr = 16'h0320; st_data = 32'h32;
        chk("R9", "closed after barrier", 64'(st_ready), 64'd0);
        tick();
        chk("R9", "still closed", 64'(st_ready), 64'd0);
        drain_one("R9", 16'h0300, 32'h30);
        chk("R9", "closed with one left", 64'(st_ready), 64'd0);
        drain_one("R9", 16'h0310, 32'h31);
        chk("R9", "closed in empty cycle", 64'(st_ready), 64'd0);
        chk("R9", "queue empty", 64'(dr_valid), 64'd0);
        tick();
        chk("R9", "reopened", 64'(st_ready), 64'd1);
        tick();
        st_valid = 1'b0;
        drain_one("R9", 16'h0320, 32'h32);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_forward();
        t_youngest();
        t_full();
        t_barrier();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule